// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a two-wire serial bus slave that gives a bus master access to four internal registers through a 2-bit register pointer. The registers are a read-only temperature word, a one-byte configuration register, and two 16-bit threshold words (a hysteresis level and an over-temperature level). Local logic loads the temperature word over a parallel port. The slave answers to a 7-bit address built from a fixed upper nibble and three strap pins. This lets up to eight copies share one bus.

Both bus lines pass through synchronizers into the system clock domain, and all bus events are found there. The block detects START, repeated START and STOP, and shifts every byte most-significant bit first. It acknowledges each byte it receives and watches the master's acknowledge during reads. It pulls SDA low only through an active-high output enable, so the line works as open drain.

In a write transaction the first data byte is always taken as the pointer. The pointer then stays where it was set, so any number of later reads return the same register without setting it again.

Top module: `ptr_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal binary 1001 followed by addr_sel_i[2:0]. On any other address it leaves SDA released for the rest of the transaction, so a byte clocked out then reads 0xFF, until the next START or STOP.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START in place of a STOP begins a new transaction whose address byte is decoded afresh.
- R3: After reset the pointer selects the temperature register (code 00), so a read with no pointer write returns the loaded temperature.
- R4: The pointer codes are 00 temperature, 01 configuration, 10 hysteresis and 11 over-temperature. The first byte after a write address sets the pointer from its two low bits, and its upper six bits are ignored. The pointer then stays unchanged for all later read transactions.
- R5: A write that carries only the pointer byte, followed by STOP or a repeated START, changes no register value.
- R6: A 16-bit register is read high byte first, then low byte. If the master keeps acknowledging, the bytes keep alternating high, low, high. A configuration read returns its one byte on every slot.
- R7: A threshold register is updated only when both data bytes (high then low) have arrived. A write that stops after one data byte leaves the register unchanged. Further data bytes are acknowledged and have no effect.
- R8: Data bytes written while the pointer is 00 are acknowledged and leave the temperature register unchanged.
- R9: A read returns the register value that was captured when the read address was accepted. A temperature load during the read changes only later reads.
- R10: A master NACK after a read byte makes the slave release SDA until the next START or STOP.
- R11: The slave acknowledges every byte it accepts by holding SDA low for the whole ninth SCL period. It changes SDA only after an SCL falling edge (or on START/STOP).
- R12: After reset the configuration register is 0x00, the hysteresis register is 0x4B00 and the over-temperature register is 0x5000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | High to pull SDA low; low releases the line |
| addr_sel_i | input | 3 | Low three bits of the slave address |
| temp_i | input | 16 | Temperature word from local logic |
| temp_load_i | input | 1 | Loads temp_i into the temperature register |

## Verification
The assertions assume that SCL and SDA change slowly compared with the system clock. Each level must hold for several clocks so that the synchronized edges stay apart. They also assume that SDA changes only while SCL is low, except to form START or STOP. The bench's bit-level master keeps to this. It holds each quarter of an SCL period for ten system clocks and changes its SDA only with SCL low, apart from the start and stop steps. The bench models the wired-AND of the master and slave drivers, so every slave bit is sampled in the middle of the SCL high time.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = 7;
  localparam int SEL_W  = 3;
  localparam int HI_W   = ADDR_W - SEL_W;

  typedef enum logic [1:0] {
    SEL_TEMP = 2'b00,
    SEL_CFG  = 2'b01,
    SEL_HYST = 2'b10,
    SEL_TOS  = 2'b11
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDAT, ST_SACK, ST_RDAT, ST_MACK, ST_IGNORE
  } bus_st_e;

  // Address byte carries the 7-bit address above the direction bit.
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [HI_W-1:0] hi,
                                    input logic [SEL_W-1:0] sel);
    return b[BYTE_W-1:1] == {hi, sel};
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                  input logic lo);
    return lo ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction

  // Configuration writes use one byte; word registers join held high + new low.
  function automatic logic [WORD_W-1:0] compose_word(input logic one_byte,
                                                     input logic [BYTE_W-1:0] hi,
                                                     input logic [BYTE_W-1:0] lo);
    return one_byte ? {{BYTE_W{1'b0}}, lo} : {hi, lo};
  endfunction
endpackage

// File: rtl/tsr_bus_sync.sv
module tsr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_lvl
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  assign sda_lvl   = sda_s;
endmodule

// File: rtl/tsr_regfile.sv
module tsr_regfile
  import tsr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RST  = 8'h00,
  parameter logic [WORD_W-1:0] HYST_RST = 16'h4B00,
  parameter logic [WORD_W-1:0] TOS_RST  = 16'h5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_load,
  input  logic [WORD_W-1:0] temp_in,
  input  logic              ptr_we,
  input  logic [1:0]        ptr_in,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  output logic [1:0]        ptr,
  output logic [WORD_W-1:0] rd_word
);
  reg_sel_e          ptr_q;
  logic [WORD_W-1:0] temp_q, hyst_q, tos_q;
  logic [BYTE_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= SEL_TEMP;
      temp_q <= '0;
      cfg_q  <= CFG_RST;
      hyst_q <= HYST_RST;
      tos_q  <= TOS_RST;
    end else begin
      if (temp_load) temp_q <= temp_in;
      if (ptr_we) ptr_q <= reg_sel_e'(ptr_in);
      if (wr_en) begin
        unique case (ptr_q)
          SEL_CFG:  cfg_q  <= wr_word[BYTE_W-1:0];
          SEL_HYST: hyst_q <= wr_word;
          SEL_TOS:  tos_q  <= wr_word;
          default:  ;
        endcase
      end
    end
  end

  assign ptr = ptr_q;

  always_comb begin
    unique case (ptr_q)
      SEL_TEMP: rd_word = temp_q;
      SEL_CFG:  rd_word = {cfg_q, cfg_q};
      SEL_HYST: rd_word = hyst_q;
      default:  rd_word = tos_q;
    endcase
  end

  // R8
  temp_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !temp_load) |=> $stable(temp_q));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_we |=> $stable(ptr_q));

  // R7
  word_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(hyst_q) && $stable(tos_q) && $stable(cfg_q)));
endmodule

// File: rtl/ptr_regbank_slave.sv
module ptr_regbank_slave
  import tsr_pkg::*;
#(
  parameter logic [HI_W-1:0]   ADDR_HI     = 4'b1001,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] CFG_RST     = 8'h00,
  parameter logic [WORD_W-1:0] HYST_RST    = 16'h4B00,
  parameter logic [WORD_W-1:0] TOS_RST     = 16'h5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic [WORD_W-1:0] temp_i,
  input  logic              temp_load_i
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  // Named bus events for the assertions.
  logic scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;
  logic rx_state, rx_done, addr_ok, ptr_we, wr_en;
  logic [1:0]        ptr;
  logic [WORD_W-1:0] rd_word, wr_word;

  bus_st_e           state, nxt_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr, msb_hold, next_tx;
  logic [WORD_W-1:0] rd_buf;
  logic [1:0]        wr_idx;
  logic              rd_lo, mack_q, oe_q;

  tsr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_lvl(sda_lvl)
  );

  tsr_regfile #(.CFG_RST(CFG_RST), .HYST_RST(HYST_RST), .TOS_RST(TOS_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .temp_load(temp_load_i), .temp_in(temp_i),
    .ptr_we(ptr_we), .ptr_in(rx_sr[1:0]), .wr_en(wr_en), .wr_word(wr_word),
    .ptr(ptr), .rd_word(rd_word)
  );

  assign rx_state = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDAT);
  assign rx_done  = rx_state && scl_fall && (cnt == FULL);
  assign addr_ok  = addr_hit(rx_sr, ADDR_HI, addr_sel_i);
  assign ptr_we   = rx_done && (state == ST_PTR);
  assign wr_en    = rx_done && (state == ST_WDAT) &&
                    ((ptr == SEL_CFG) ? (wr_idx == 2'd0) : (wr_idx == 2'd1));
  assign wr_word  = compose_word(ptr == SEL_CFG, msb_hold, rx_sr);
  assign next_tx  = pick_byte(rd_buf, ~rd_lo);
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      cnt      <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      msb_hold <= '0;
      rd_buf   <= '0;
      wr_idx   <= '0;
      rd_lo    <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else if (stop_evt) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else if (start_evt) begin
      state <= ST_ADDR;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise && cnt != FULL) begin
            rx_sr <= {rx_sr[BYTE_W-2:0], sda_lvl};
            cnt   <= cnt + CNT_W'(1);
          end else if (rx_done) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_ok) begin
                oe_q   <= 1'b1;
                state  <= ST_SACK;
                nxt_q  <= rx_sr[0] ? ST_RDAT : ST_PTR;
                rd_buf <= rd_word;
                rd_lo  <= 1'b0;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              oe_q  <= 1'b1;
              state <= ST_SACK;
              nxt_q <= ST_WDAT;
              if (state == ST_PTR) begin
                wr_idx <= '0;
              end else begin
                if (wr_idx == 2'd0) msb_hold <= rx_sr;
                if (wr_idx != 2'd2) wr_idx <= wr_idx + 2'd1;
              end
            end
          end
        end
        ST_SACK: begin
          if (scl_fall) begin
            if (nxt_q == ST_RDAT) begin
              tx_sr <= pick_byte(rd_buf, 1'b0);
              oe_q  <= ~rd_buf[WORD_W-1];
              cnt   <= '0;
            end else begin
              oe_q <= 1'b0;
            end
            state <= nxt_q;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              oe_q  <= 1'b0;
              state <= ST_MACK;
            end else begin
              tx_sr <= tx_sr << 1;
              oe_q  <= ~tx_sr[BYTE_W-2];
              cnt   <= cnt + CNT_W'(1);
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_q <= ~sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              rd_lo <= ~rd_lo;
              tx_sr <= next_tx;
              oe_q  <= ~next_tx[BYTE_W-1];
              cnt   <= '0;
              state <= ST_RDAT;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && state == ST_ADDR && !addr_ok) |=> !sda_oe_o);

  // R10
  ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe_o);

  // R11
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SACK) |-> sda_oe_o);

  // R11
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !start_evt && !stop_evt) |=> $stable(sda_oe_o));

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe_o));

  // R2
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_ADDR && cnt == '0));
endmodule

// File: tb/test_ptr_regbank_slave.sv
module test_ptr_regbank_slave;
  localparam int Q = 10;
  localparam logic [7:0] AW  = 8'h9A;  // 1001_101 + write
  localparam logic [7:0] AR  = 8'h9B;  // 1001_101 + read
  localparam logic [7:0] BAD = 8'h98;  // 1001_100 + write

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic temp_load = 1'b0;
  logic [2:0] sel = 3'b101;
  logic [15:0] temp_v = '0;
  logic sda_oe, sda_line;
  int checks = 0;
  int errors = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  ptr_regbank_slave i_ptr_regbank_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .temp_i(temp_v), .temp_load_i(temp_load)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); sda_m = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl = 1'b1; qw(); b = sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic wbyte_chk(input logic [7:0] d, input string req);
    logic a;
    wbyte(d, a);
    check(req, 16'(a), 16'h1);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack);
  endtask

  task automatic load_temp(input logic [15:0] v);
    @(negedge clk); temp_v = v; temp_load = 1'b1;
    @(negedge clk); temp_load = 1'b0;
  endtask

  task automatic read_word(output logic [15:0] w);
    logic [7:0] h, l;
    bus_start();
    wbyte_chk(AR, "R1 read address ack");
    rbyte(h, 1'b1);
    rbyte(l, 1'b0);
    bus_stop();
    w = {h, l};
  endtask

  task automatic set_ptr_stop(input logic [7:0] p);
    bus_start(); wbyte_chk(AW, "R1 write address ack"); wbyte_chk(p, "R11 pointer ack"); bus_stop();
  endtask

  task automatic t_reset_read();
    logic [15:0] w;
    check("R11 reset sda released", 16'(sda_oe), 16'h0);
    load_temp(16'h1A80);
    read_word(w);
    check("R3 reset pointer reads temperature", w, 16'h1A80);
  endtask

  task automatic t_reset_values();
    logic [7:0] c;
    logic [15:0] w;
    bus_start(); wbyte_chk(AW, "R1 ack"); wbyte_chk(8'h01, "R4 ptr ack");
    bus_start(); wbyte_chk(AR, "R2 repeated start read ack");
    rbyte(c, 1'b0); bus_stop();
    check("R12 cfg reset value", 16'(c), 16'h0000);
    set_ptr_stop(8'h02); read_word(w);
    check("R12 hysteresis reset value", w, 16'h4B00);
    set_ptr_stop(8'h03); read_word(w);
    check("R12 over-temp reset value", w, 16'h5000);
  endtask

  task automatic t_address();
    logic a;
    logic [7:0] d;
    bus_start(); wbyte(BAD, a);
    check("R1 wrong address nack", 16'(a), 16'h0);
    rbyte(d, 1'b0);
    check("R1 ignored slave stays off bus", 16'(d), 16'h00FF);
    bus_start(); wbyte(AR, a);
    check("R2 repeated start after mismatch acked", 16'(a), 16'h1);
    rbyte(d, 1'b0); bus_stop();
    check("R4 pointer persists (over-temp MSB)", 16'(d), 16'h0050);
  endtask

  task automatic t_write_hyst();
    logic [15:0] w;
    bus_start(); wbyte_chk(AW, "R1 ack"); wbyte_chk(8'h02, "R11 ptr ack");
    wbyte_chk(8'h12, "R11 data ack"); wbyte_chk(8'h34, "R11 data ack"); bus_stop();
    read_word(w);
    check("R7 hysteresis written", w, 16'h1234);
    read_word(w);
    check("R4 pointer persists across reads", w, 16'h1234);
  endtask

  task automatic t_cfg();
    logic [7:0] a, b;
    bus_start(); wbyte_chk(AW, "R1 ack"); wbyte_chk(8'hFD, "R4 ptr ack");
    wbyte_chk(8'hA5, "R11 cfg ack"); bus_stop();
    bus_start(); wbyte_chk(AR, "R1 ack");
    rbyte(a, 1'b1); rbyte(b, 1'b0); bus_stop();
    check("R4 upper pointer bits ignored, cfg", 16'(a), 16'h00A5);
    check("R6 cfg repeats on next slot", 16'(b), 16'h00A5);
  endtask

  task automatic t_ptr_only();
    logic [15:0] w;
    set_ptr_stop(8'h03); read_word(w);
    check("R5 pointer-only write keeps over-temp", w, 16'h5000);
    set_ptr_stop(8'h02); read_word(w);
    check("R5 pointer-only write keeps hysteresis", w, 16'h1234);
  endtask

  task automatic t_partial();
    logic [15:0] w;
    logic [7:0] d;
    bus_start(); wbyte_chk(AW, "R1 ack"); wbyte_chk(8'h03, "R4 ack");
    wbyte_chk(8'h77, "R7 lone byte ack"); bus_stop();
    read_word(w);
    check("R7 single data byte discarded", w, 16'h5000);
    bus_start(); wbyte_chk(AW, "R1 ack"); wbyte_chk(8'h03, "R4 ack");
    wbyte_chk(8'h60, "R7 ack"); wbyte_chk(8'h0A, "R7 ack");
    wbyte_chk(8'hEE, "R7 extra byte ack"); wbyte_chk(8'hFF, "R7 extra byte ack"); bus_stop();
    read_word(w);
    check("R7 extra bytes ignored", w, 16'h600A);
    bus_start(); wbyte_chk(AW, "R1 ack"); wbyte_chk(8'h02, "R4 ack");
    wbyte_chk(8'hAB, "R7 ack");
    bus_start(); wbyte_chk(AR, "R2 repeated start ack");
    rbyte(d, 1'b0); bus_stop();
    check("R2 repeated start ends write, R7 discards", 16'(d), 16'h0012);
  endtask

  task automatic t_temp_ro();
    logic [15:0] w;
    bus_start(); wbyte_chk(AW, "R1 ack"); wbyte_chk(8'h00, "R8 ptr ack");
    wbyte_chk(8'hDE, "R8 data ack"); wbyte_chk(8'hAD, "R8 data ack"); bus_stop();
    read_word(w);
    check("R8 temperature unchanged by write", w, 16'h1A80);
  endtask

  task automatic t_wrap();
    logic [7:0] a, b, c;
    set_ptr_stop(8'h03);
    bus_start(); wbyte_chk(AR, "R1 ack");
    rbyte(a, 1'b1); rbyte(b, 1'b1); rbyte(c, 1'b0); bus_stop();
    check("R6 first byte is high", 16'(a), 16'h0060);
    check("R6 second byte is low", 16'(b), 16'h000A);
    check("R6 third byte wraps to high", 16'(c), 16'h0060);
  endtask

  task automatic t_snapshot();
    logic [7:0] h, l;
    logic [15:0] w;
    set_ptr_stop(8'h00);
    bus_start(); wbyte_chk(AR, "R1 ack");
    rbyte(h, 1'b1);
    load_temp(16'h2B10);
    rbyte(l, 1'b0); bus_stop();
    check("R9 read uses captured word", {h, l}, 16'h1A80);
    read_word(w);
    check("R9 next read sees new temperature", w, 16'h2B10);
  endtask

  task automatic t_nack();
    logic [7:0] d;
    bus_start(); wbyte_chk(AR, "R1 ack");
    rbyte(d, 1'b0);
    check("R10 byte before nack", 16'(d), 16'h002B);
    check("R10 sda released after nack", 16'(sda_oe), 16'h0);
    rbyte(d, 1'b0);
    check("R10 no drive after nack", 16'(d), 16'h00FF);
    bus_stop();
    check("R2 stop leaves sda released", 16'(sda_oe), 16'h0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_read();
    t_reset_values();
    t_address();
    t_write_hyst();
    t_cfg();
    t_ptr_only();
    t_partial();
    t_temp_ro();
    t_wrap();
    t_snapshot();
    t_nack();
    finish_run();
  end
endmodule